// File: doc/BRIEF.md
# Port-Mapped NAND Flash Bridge

This block connects a simple synchronous host bus to as many as three raw NAND flash banks. The host has an active-low chip select, a 4-bit port address, separate active-low read and write strobes, and an 8-bit data path. The bridge decodes the port address into a flash data port, a command-latch port, an address-latch port, a control register and a status port. Each write to one of the three flash ports produces one active-low strobe on the flash side, one clock long, with the byte placed on `flash_dout`.

The control register selects one bank and drives its chip enable. It also releases the write-protect line, which all banks share. Write-protect is driven active whenever the reset input is high, so the array stays protected while supply rails ramp. The flash ready line is passed to the host on a pin and in the status port.

An optional preload sequencer runs once after reset when `init_req` is high. It enables every bank and sends the gapless-read command 02h, then three zero address bytes. It then waits for the flash to report ready before it raises `preload_done`, so the first page can be read at once. Host accesses are locked out while the sequence runs.

Top module: `nand_port_bridge`

## Requirements
- R1: In the first cycle after synchronous reset ends, all chip enables are high, write-protect is low, every flash strobe and `flash_rd_n` are high, and `preload_done` is 0.
- R2: While `rst` is high, `flash_wp_n` is low in the same cycle, even if the write-protect release bit was set.
- R3: A write to port 1 gives one low cycle on `flash_cmd_stb_n`. A write to port 2 does the same on `flash_addr_stb_n`, and a write to port 0 on `flash_data_stb_n`. The pulse appears in the cycle after the first clock edge that sees the qualified write, with the host byte on `flash_dout`. A write strobe held low for several cycles still gives only one pulse.
- R4: A write strobe with `host_cs_n` high, or a cycle with `host_cs_n` low and no strobe active, produces no flash strobe and leaves the control register unchanged.
- R5: Port 3 bits [1:0] pick a bank and bit 2 enables it. With bit 2 set, only `flash_ce_n[bank]` is low. With bit 2 clear, or with a bank number of NUM_BANKS or more, all chip enables are high.
- R6: Port 3 bit 3 set drives the shared `flash_wp_n` high. Clearing the bit drives it low again.
- R7: A port 3 read returns the control register in bits [3:0] and zero above. A port 4 read returns `flash_rdy` in bit 0 and zero above. Reads of ports 1, 2 and 5 to 15 return 0. `host_rb` always follows `flash_rdy`.
- R8: During a qualified read of port 0, `flash_rd_n` is low and `host_rdata` equals `flash_din`. At all other times `flash_rd_n` is high.
- R9: With `init_req` high after reset, the bridge drives every chip enable low. It issues one command strobe carrying 02h, then three address strobes carrying 00h. It raises `preload_done` only after `flash_rdy` is seen high, then releases the chip enables. It does not run the sequence again until the next reset.
- R10: While the preload sequence runs, host writes are ignored. They produce no strobe and leave the control register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also forces write-protect |
| host_cs_n | input | 1 | Host chip select, active low |
| host_addr | input | 4 | Host port address |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational |
| host_rb | output | 1 | Flash ready/busy passed to the host |
| init_req | input | 1 | Request the power-up page preload |
| preload_done | output | 1 | Preload sequence complete |
| flash_ce_n | output | NUM_BANKS | Per-bank chip enables, active low |
| flash_wp_n | output | 1 | Shared write-protect, active low |
| flash_cmd_stb_n | output | 1 | Command latch strobe, active low |
| flash_addr_stb_n | output | 1 | Address latch strobe, active low |
| flash_data_stb_n | output | 1 | Data write strobe, active low |
| flash_rd_n | output | 1 | Flash read enable, active low |
| flash_dout | output | 8 | Byte sent to the flash |
| flash_din | input | 8 | Byte read from the flash |
| flash_rdy | input | 1 | Flash ready (high) / busy (low) |

## Verification
The assertions assume the host inputs are synchronous to `clk` and that reset is applied from time zero. The bench drives every input on the falling edge, and reset is high from the first cycle. The properties also assume the host does not hold a write strobe low across the start of the preload sequence. The bench issues every host write with the strobe released between accesses and starts the preload only while the host bus is idle.

// File: rtl/nand_bridge_pkg.sv
package nand_bridge_pkg;
    localparam int PORT_W = 4;
    localparam int BYTE_W = 8;
    localparam int CTRL_W = 4;

    localparam logic [PORT_W-1:0] PORT_DATA = 4'd0;
    localparam logic [PORT_W-1:0] PORT_CMD  = 4'd1;
    localparam logic [PORT_W-1:0] PORT_ADDR = 4'd2;
    localparam logic [PORT_W-1:0] PORT_CTRL = 4'd3;
    localparam logic [PORT_W-1:0] PORT_STAT = 4'd4;

    localparam logic [BYTE_W-1:0] GAPLESS_READ_OP = 8'h02;

    typedef enum logic [1:0] {STB_NONE, STB_CMD, STB_ADDR, STB_DATA} stb_kind_e;

    typedef struct packed {
        stb_kind_e         kind;
        logic [BYTE_W-1:0] data;
    } stb_req_t;

    typedef struct packed {
        logic       wp_release;
        logic       ce_on;
        logic [1:0] bank;
    } ctrl_t;

    function automatic stb_kind_e port_kind(input logic [PORT_W-1:0] port);
        case (port)
            PORT_DATA: return STB_DATA;
            PORT_CMD:  return STB_CMD;
            PORT_ADDR: return STB_ADDR;
            default:   return STB_NONE;
        endcase
    endfunction
endpackage

// File: rtl/bridge_host_decode.sv
module bridge_host_decode
    import nand_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic [PORT_W-1:0] addr,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              hold,
    input  ctrl_t             ctrl_q,
    input  logic              flash_rdy,
    input  logic [BYTE_W-1:0] flash_din,
    output stb_req_t          wr_req,
    output logic              ctrl_we,
    output logic [BYTE_W-1:0] rdata,
    output logic              rd_flash_n
);
    logic wr_q, rd_q, wr_q_d, wr_edge;

    assign wr_q    = !cs_n && !wr_n;
    assign rd_q    = !cs_n && !rd_n;
    assign wr_edge = wr_q && !wr_q_d && !hold;

    always_ff @(posedge clk) begin
        if (rst) wr_q_d <= 1'b0;
        else     wr_q_d <= wr_q;
    end

    always_comb begin
        wr_req.kind = wr_edge ? port_kind(addr) : STB_NONE;
        wr_req.data = wdata;
        ctrl_we     = wr_edge && (addr == PORT_CTRL);
    end

    assign rd_flash_n = !(rd_q && !hold && addr == PORT_DATA);

    always_comb begin
        rdata = '0;
        if (rd_q && !hold) begin
            case (addr)
                PORT_DATA: rdata = flash_din;
                PORT_CTRL: rdata = {{(BYTE_W-CTRL_W){1'b0}}, ctrl_q};
                PORT_STAT: rdata = {{(BYTE_W-1){1'b0}}, flash_rdy};
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/bridge_ctrl_reg.sv
module bridge_ctrl_reg
    import nand_bridge_pkg::*;
#(
    parameter int NUM_BANKS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              pl_busy,
    output ctrl_t             ctrl_q,
    output logic [NUM_BANKS-1:0] ce_n,
    output logic              wp_n
);
    always_ff @(posedge clk) begin
        if (rst)     ctrl_q <= '0;
        else if (we) ctrl_q <= ctrl_t'(wdata);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign ce_n[b] = !(pl_busy || (ctrl_q.ce_on && ctrl_q.bank == 2'(b)));
    end

    assign wp_n = ctrl_q.wp_release && !rst;

    a_r5_single_bank: assert property (@(posedge clk) disable iff (rst)
        !pl_busy |-> ($countones(~ce_n) <= 1));
    a_r6_wp_follows_release: assert property (@(posedge clk) disable iff (rst)
        (we && !wdata[3]) |=> !wp_n);
endmodule

// File: rtl/bridge_preload_seq.sv
module bridge_preload_seq
    import nand_bridge_pkg::*;
#(
    parameter int ADDR_BYTES = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     init_req,
    input  logic     flash_rdy,
    output logic     busy,
    output logic     done,
    output stb_req_t req
);
    localparam int STEPS  = 2 * (1 + ADDR_BYTES);
    localparam int STEP_W = $clog2(STEPS);

    typedef enum logic [1:0] {PL_IDLE, PL_RUN, PL_WAIT} pl_state_e;

    pl_state_e         state;
    logic [STEP_W-1:0] step;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PL_IDLE;
            step  <= '0;
            done  <= 1'b0;
        end else begin
            case (state)
                PL_IDLE: if (init_req && !done) begin
                    state <= PL_RUN;
                    step  <= '0;
                end
                PL_RUN: begin
                    if (step == STEP_W'(STEPS - 1)) state <= PL_WAIT;
                    step <= step + 1'b1;
                end
                PL_WAIT: if (flash_rdy) begin
                    state <= PL_IDLE;
                    done  <= 1'b1;
                end
                default: state <= PL_IDLE;
            endcase
        end
    end

    assign busy = (state != PL_IDLE);

    always_comb begin
        req.kind = STB_NONE;
        req.data = '0;
        if (state == PL_RUN && !step[0]) begin
            req.kind = (step == '0) ? STB_CMD : STB_ADDR;
            req.data = (step == '0) ? GAPLESS_READ_OP : '0;
        end
    end

    a_r9_done_needs_ready: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(flash_rdy));
    a_r9_runs_once: assert property (@(posedge clk) disable iff (rst)
        done |=> (state == PL_IDLE));
endmodule

// File: rtl/bridge_strobe_gen.sv
module bridge_strobe_gen
    import nand_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  stb_req_t          req,
    output logic              cmd_n,
    output logic              addr_n,
    output logic              data_n,
    output logic [BYTE_W-1:0] dout
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_n  <= 1'b1;
            addr_n <= 1'b1;
            data_n <= 1'b1;
            dout   <= '0;
        end else begin
            cmd_n  <= (req.kind != STB_CMD);
            addr_n <= (req.kind != STB_ADDR);
            data_n <= (req.kind != STB_DATA);
            if (req.kind != STB_NONE) dout <= req.data;
        end
    end

    a_r3_cmd_one_cycle: assert property (@(posedge clk) disable iff (rst)
        !cmd_n |=> cmd_n);
    a_r3_addr_one_cycle: assert property (@(posedge clk) disable iff (rst)
        !addr_n |=> addr_n);
    a_r3_data_one_cycle: assert property (@(posedge clk) disable iff (rst)
        !data_n |=> data_n);
    a_r3_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({!cmd_n, !addr_n, !data_n}));
endmodule

// File: rtl/nand_port_bridge.sv
module nand_port_bridge
    import nand_bridge_pkg::*;
#(
    parameter int NUM_BANKS  = 3,
    parameter int ADDR_BYTES = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 host_cs_n,
    input  logic [3:0]           host_addr,
    input  logic                 host_rd_n,
    input  logic                 host_wr_n,
    input  logic [7:0]           host_wdata,
    output logic [7:0]           host_rdata,
    output logic                 host_rb,
    input  logic                 init_req,
    output logic                 preload_done,
    output logic [NUM_BANKS-1:0] flash_ce_n,
    output logic                 flash_wp_n,
    output logic                 flash_cmd_stb_n,
    output logic                 flash_addr_stb_n,
    output logic                 flash_data_stb_n,
    output logic                 flash_rd_n,
    output logic [7:0]           flash_dout,
    input  logic [7:0]           flash_din,
    input  logic                 flash_rdy
);
    stb_req_t host_req, pl_req, stb_req;
    ctrl_t    ctrl_q;
    logic     ctrl_we, pl_busy;

    bridge_preload_seq #(.ADDR_BYTES(ADDR_BYTES)) u_preload (
        .clk(clk), .rst(rst), .init_req(init_req), .flash_rdy(flash_rdy),
        .busy(pl_busy), .done(preload_done), .req(pl_req)
    );

    bridge_host_decode u_decode (
        .clk(clk), .rst(rst), .cs_n(host_cs_n), .addr(host_addr),
        .rd_n(host_rd_n), .wr_n(host_wr_n), .wdata(host_wdata),
        .hold(pl_busy), .ctrl_q(ctrl_q), .flash_rdy(flash_rdy),
        .flash_din(flash_din), .wr_req(host_req), .ctrl_we(ctrl_we),
        .rdata(host_rdata), .rd_flash_n(flash_rd_n)
    );

    bridge_ctrl_reg #(.NUM_BANKS(NUM_BANKS)) u_ctrl (
        .clk(clk), .rst(rst), .we(ctrl_we), .wdata(host_wdata[CTRL_W-1:0]),
        .pl_busy(pl_busy), .ctrl_q(ctrl_q), .ce_n(flash_ce_n), .wp_n(flash_wp_n)
    );

    assign stb_req = pl_busy ? pl_req : host_req;

    bridge_strobe_gen u_strobe (
        .clk(clk), .rst(rst), .req(stb_req), .cmd_n(flash_cmd_stb_n),
        .addr_n(flash_addr_stb_n), .data_n(flash_data_stb_n), .dout(flash_dout)
    );

    assign host_rb = flash_rdy;

    a_r1_wp_low_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!flash_wp_n && &flash_ce_n));
    a_r10_ctrl_frozen_in_preload: assert property (@(posedge clk) disable iff (rst)
        pl_busy |=> $stable(ctrl_q));
    a_r9_all_banks_in_preload: assert property (@(posedge clk) disable iff (rst)
        pl_busy |-> (flash_ce_n == '0));
endmodule

// File: tb/nand_port_bridge_bench.sv
module nand_port_bridge_bench;
    localparam int NB = 3;

    logic clk = 0, rst = 1;
    logic host_cs_n = 1, host_rd_n = 1, host_wr_n = 1, init_req = 0, flash_rdy = 1;
    logic [3:0] host_addr = 0;
    logic [7:0] host_wdata = 0, flash_din = 0;
    logic [7:0] host_rdata, flash_dout;
    logic host_rb, preload_done, flash_wp_n, flash_rd_n;
    logic flash_cmd_stb_n, flash_addr_stb_n, flash_data_stb_n;
    logic [NB-1:0] flash_ce_n;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    nand_port_bridge #(.NUM_BANKS(NB)) u_nand_port_bridge (
        .clk(clk), .rst(rst), .host_cs_n(host_cs_n), .host_addr(host_addr),
        .host_rd_n(host_rd_n), .host_wr_n(host_wr_n), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rb(host_rb), .init_req(init_req),
        .preload_done(preload_done), .flash_ce_n(flash_ce_n), .flash_wp_n(flash_wp_n),
        .flash_cmd_stb_n(flash_cmd_stb_n), .flash_addr_stb_n(flash_addr_stb_n),
        .flash_data_stb_n(flash_data_stb_n), .flash_rd_n(flash_rd_n),
        .flash_dout(flash_dout), .flash_din(flash_din), .flash_rdy(flash_rdy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] strobes();
        return {flash_cmd_stb_n, flash_addr_stb_n, flash_data_stb_n};
    endfunction

    // one write; returns strobes and byte seen in the cycle after the edge
    task automatic do_write(input logic [3:0] a, input logic [7:0] d, input logic cs,
                            output logic [2:0] stb, output logic [7:0] q);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_cs_n = cs; host_wr_n = 0;
        @(negedge clk);
        stb = strobes(); q = flash_dout;
        host_wr_n = 1; host_cs_n = 1;
        @(negedge clk);
    endtask

    task automatic do_read(input logic [3:0] a, output logic [7:0] q, output logic rdn);
        @(negedge clk);
        host_addr = a; host_cs_n = 0; host_rd_n = 0;
        #1; q = host_rdata; rdn = flash_rd_n;
        @(negedge clk);
        host_rd_n = 1; host_cs_n = 1;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(flash_ce_n == '1, "R1 ce after reset", flash_ce_n, 7);
        check(flash_wp_n == 0, "R1 wp after reset", flash_wp_n, 0);
        check(strobes() == 3'b111 && flash_rd_n, "R1 strobes after reset", strobes(), 7);
        check(preload_done == 0, "R1 done after reset", preload_done, 0);
    endtask

    task automatic t_strobes();
        logic [2:0] s; logic [7:0] q; int lows;
        do_write(4'd1, 8'h70, 0, s, q);
        check(s == 3'b011 && q == 8'h70, "R3 cmd strobe", {s, q}, {3'b011, 8'h70});
        check(strobes() == 3'b111, "R3 cmd released", strobes(), 7);
        do_write(4'd2, 8'h5A, 0, s, q);
        check(s == 3'b101 && q == 8'h5A, "R3 addr strobe", {s, q}, {3'b101, 8'h5A});
        do_write(4'd0, 8'hC3, 0, s, q);
        check(s == 3'b110 && q == 8'hC3, "R3 data strobe", {s, q}, {3'b110, 8'hC3});
        // long strobe: one pulse only
        @(negedge clk);
        host_addr = 4'd1; host_wdata = 8'h90; host_cs_n = 0; host_wr_n = 0;
        lows = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (!flash_cmd_stb_n) lows++;
        end
        host_wr_n = 1; host_cs_n = 1;
        @(negedge clk);
        check(lows == 1, "R3 held strobe single pulse", lows, 1);
    endtask

    task automatic t_no_access();
        logic [2:0] s; logic [7:0] q; logic rdn; int lows;
        do_write(4'd1, 8'hEE, 1, s, q);
        check(s == 3'b111, "R4 no strobe without cs", s, 7);
        do_write(4'd3, 8'h07, 1, s, q);
        do_read(4'd3, q, rdn);
        check(q == 8'h00 && flash_ce_n == '1, "R4 ctrl untouched without cs", q, 0);
        @(negedge clk);
        host_cs_n = 0; host_addr = 4'd1; lows = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (strobes() != 3'b111) lows++;
        end
        host_cs_n = 1;
        check(lows == 0, "R4 no strobe with cs only", lows, 0);
    endtask

    task automatic t_banks();
        logic [2:0] s; logic [7:0] q;
        for (int b = 0; b < 4; b++) begin
            do_write(4'd3, 8'(4 | b), 0, s, q);
            if (b < NB)
                check(flash_ce_n == ~(NB'(1) << b), "R5 bank select", flash_ce_n, ~(NB'(1) << b));
            else
                check(flash_ce_n == '1, "R5 bank out of range", flash_ce_n, 7);
        end
        do_write(4'd3, 8'h01, 0, s, q);
        check(flash_ce_n == '1, "R5 enable bit clear", flash_ce_n, 7);
    endtask

    task automatic t_wp();
        logic [2:0] s; logic [7:0] q;
        do_write(4'd3, 8'h08, 0, s, q);
        check(flash_wp_n == 1, "R6 wp released", flash_wp_n, 1);
        do_write(4'd3, 8'h00, 0, s, q);
        check(flash_wp_n == 0, "R6 wp reapplied", flash_wp_n, 0);
        do_write(4'd3, 8'h0D, 0, s, q);
        @(negedge clk); rst = 1; #1;
        check(flash_wp_n == 0, "R2 wp forced in reset", flash_wp_n, 0);
        @(negedge clk); #1;
        check(flash_wp_n == 0, "R2 wp held in reset", flash_wp_n, 0);
        rst = 0;
        @(negedge clk);
        check(flash_wp_n == 0 && flash_ce_n == '1, "R1 ctrl cleared by reset", {flash_wp_n, flash_ce_n}, 7);
    endtask

    task automatic t_reads();
        logic [2:0] s; logic [7:0] q; logic rdn;
        do_write(4'd3, 8'h0E, 0, s, q);
        do_read(4'd3, q, rdn);
        check(q == 8'h0E, "R7 ctrl readback", q, 8'h0E);
        flash_rdy = 0;
        do_read(4'd4, q, rdn);
        check(q == 8'h00 && host_rb == 0, "R7 status busy", {host_rb, q}, 0);
        flash_rdy = 1;
        do_read(4'd4, q, rdn);
        check(q == 8'h01 && host_rb == 1, "R7 status ready", {host_rb, q}, 9'h101);
        do_read(4'd9, q, rdn);
        check(q == 8'h00 && rdn == 1, "R7 unused port zero", q, 0);
        do_read(4'd1, q, rdn);
        check(q == 8'h00, "R7 cmd port reads zero", q, 0);
        flash_din = 8'hA7;
        do_read(4'd0, q, rdn);
        check(q == 8'hA7 && rdn == 0, "R8 data read", {rdn, q}, 8'hA7);
        #1;
        check(flash_rd_n == 1, "R8 rd_n idle", flash_rd_n, 1);
        do_write(4'd3, 8'h00, 0, s, q);
    endtask

    task automatic t_preload();
        logic [2:0] s; logic [7:0] q; logic rdn;
        int ncmd = 0, naddr = 0, bad = 0, cebad = 0;
        logic [7:0] cmd_byte = 8'hFF;
        @(negedge clk); rst = 1; @(negedge clk); rst = 0;
        flash_rdy = 0; init_req = 1;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (!flash_cmd_stb_n) begin ncmd++; cmd_byte = flash_dout; if (naddr != 0) bad++; end
            if (!flash_addr_stb_n) begin naddr++; if (flash_dout != 0) bad++; end
            if (strobes() != 3'b111 && flash_ce_n != '0) cebad++;
        end
        check(ncmd == 1 && cmd_byte == 8'h02, "R9 read command 02h", cmd_byte, 2);
        check(naddr == 3 && bad == 0, "R9 three zero address bytes", naddr, 3);
        check(cebad == 0 && flash_ce_n == '0, "R9 all banks enabled", flash_ce_n, 0);
        do_write(4'd1, 8'hAA, 0, s, q);
        check(s == 3'b111, "R10 host cmd ignored", s, 7);
        do_write(4'd3, 8'h0C, 0, s, q);
        check(preload_done == 0, "R9 waits for ready", preload_done, 0);
        flash_rdy = 1;
        @(negedge clk); @(negedge clk);
        check(preload_done == 1 && flash_ce_n == '1, "R9 done after ready", {preload_done, flash_ce_n}, 4'b1111);
        do_read(4'd3, q, rdn);
        check(q == 8'h00, "R10 ctrl unchanged by held-off write", q, 0);
        ncmd = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (strobes() != 3'b111) ncmd++;
        end
        check(ncmd == 0 && preload_done == 1, "R9 no rerun", ncmd, 0);
        init_req = 0;
    endtask

    initial begin
        t_reset();
        t_strobes();
        t_no_access();
        t_banks();
        t_wp();
        t_reads();
        t_preload();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule